// File: doc/BRIEF.md
# Shared Bus Register Datapath

This block is the register file and transfer bus of a small accumulator-style processor. Six working registers sit on one 16-bit bus: an address register, a program counter, a data register, an accumulator, an instruction register and a temporary register. Memory read data can also drive the bus. A 3-bit select code chooses the single source that drives the bus in a cycle, and any register whose load strobe is set captures the bus value at the next rising clock edge.

The address register and the program counter are 12 bits wide, and the other registers are 16 bits wide. A 12-bit register that drives the bus fills the upper four bits with zeros. A 12-bit register that loads from the bus keeps only the low twelve bits. The memory address always comes from the address register. Memory write data is the bus value.

The accumulator does not load from the bus. It loads the result of an external adder/logic unit, which lets the accumulator and another register swap values in one edge. Every register also has a synchronous increment and a synchronous clear. An 8-bit output character register captures the low byte of the bus. The control sequencer drives all strobes and the select code.

Top module: `shared_bus_datapath`

## Requirements
- R1: A synchronous active-low reset sets every register, including the output character register, to zero.
- R2: The bus is driven according to the select code: 1 for the address register, 2 for the program counter, 3 for the data register, 4 for the accumulator, 5 for the instruction register, 6 for the temporary register and 7 for memory read data. Code 0 drives all zeros.
- R3: When the address register or the program counter drives the bus, bus bits 15..12 are zero.
- R4: When the address register or the program counter loads from the bus, it takes bus bits 11..0.
- R5: The memory address output always equals the address register.
- R6: A register whose load strobe is set holds the bus value after the next rising edge. Strobe vectors use bit 0 for the address register, 1 for the program counter, 2 for the data register, 3 for the accumulator, 4 for the instruction register and 5 for the temporary register.
- R7: The accumulator load takes the adder/logic result, not the bus, so a data register and accumulator exchange completes in one edge.
- R8: Increment adds one modulo the register width: a 12-bit register at 0xFFF goes to 0, and a 16-bit register at 0xFFFF goes to 0.
- R9: When strobes are set together on one register, clear wins over load, and load wins over increment.
- R10: The memory write data output always equals the bus value.
- R11: The output character register loads bus bits 7..0 when its load strobe is set.
- R12: A register with no strobe set keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 3 | Bus source select code |
| ld_strb | input | 6 | Per-register load strobes |
| inc_strb | input | 6 | Per-register increment strobes |
| clr_strb | input | 6 | Per-register clear strobes |
| out_ld | input | 1 | Output character register load |
| mem_rdata | input | 16 | Memory read data |
| alu_result | input | 16 | Adder/logic result for the accumulator |
| bus_value | output | 16 | Current bus value |
| mem_addr | output | 12 | Memory address (address register) |
| mem_wdata | output | 16 | Memory write data |
| ac_q | output | 16 | Accumulator contents |
| dr_q | output | 16 | Data register contents |
| ir_q | output | 16 | Instruction register contents |
| out_char | output | 8 | Output character register |

## Verification
The bus value, the memory write data and the memory address are combinational views, so they are correct in the same cycle that the select code or the address register changes. Every register update from a load, increment or clear appears one rising edge after the strobe. The bench sets the strobes after a falling edge and removes them 1 ns after the next rising edge. It then sets a read-back select code and samples the bus 1 ns later, well before the following rising edge. Each update is therefore seen exactly one edge after its stimulus, through the normal bus path.

// File: rtl/shared_bus_pkg.sv
// Package: shared types and constants for the shared bus register datapath.
// It assumes six working registers plus a memory-data source on the bus.
package shared_bus_pkg;

    localparam int NUM_REGS = 6;
    localparam int NUM_SRC  = NUM_REGS + 1;
    localparam int SEL_W    = $clog2(NUM_SRC + 1);

    // Register slot positions, used in the strobe vectors and the source array.
    localparam int IDX_AR = 0;
    localparam int IDX_PC = 1;
    localparam int IDX_DR = 2;
    localparam int IDX_AC = 3;
    localparam int IDX_IR = 4;
    localparam int IDX_TR = 5;
    localparam int IDX_MEM = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 3'd0,
        SEL_AR   = 3'd1,
        SEL_PC   = 3'd2,
        SEL_DR   = 3'd3,
        SEL_AC   = 3'd4,
        SEL_IR   = 3'd5,
        SEL_TR   = 3'd6,
        SEL_MEM  = 3'd7
    } bus_sel_e;

endpackage

// File: rtl/bus_reg.sv
// Module: bus_reg
// A W-bit register with synchronous clear, parallel load and increment.
// Priority is clear, then load, then increment. The reset is synchronous
// and active low. It assumes the strobes are stable around the rising edge.
module bus_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    // Pick the next value from the strobes in priority order.
    always_comb begin
        q_next = q;
        if (clr)      q_next = '0;
        else if (ld)  q_next = d;
        else if (inc) q_next = q + W'(1);
    end

    // Store the register state.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    p_load_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !clr) |=> (q == $past(d)));

    p_inc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && !clr) |=> (q == $past(q) + W'(1)));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld && !clr) |=> $stable(q));

endmodule

// File: rtl/bus_source_mux.sv
// Module: bus_source_mux
// Drives the shared bus from one source chosen by the select code. Code k
// (k >= 1) picks source k-1, and code 0 drives zeros. It assumes the sources
// are already zero-extended to the bus width.
module bus_source_mux
    import shared_bus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] src [NUM_SRC],
    output logic [DATA_W-1:0] bus
);

    // Route the selected source onto the bus, or zeros when nothing is selected.
    always_comb begin
        bus = '0;
        if (sel != SEL_W'(SEL_NONE)) bus = src[sel - SEL_W'(1)];
    end

endmodule

// File: rtl/shared_bus_datapath.sv
// Module: shared_bus_datapath
// Top of the shared bus register datapath. It holds six working registers
// and an output character register, all loading from a single bus. The
// accumulator loads the external adder/logic result instead of the bus.
// Address-width registers are zero-extended when they drive the bus and
// truncated when they load from it. It assumes the control sequencer
// guarantees one bus source per cycle through the select code.
module shared_bus_datapath
    import shared_bus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int IO_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [NUM_REGS-1:0] ld_strb,
    input  logic [NUM_REGS-1:0] inc_strb,
    input  logic [NUM_REGS-1:0] clr_strb,
    input  logic                out_ld,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [DATA_W-1:0]   alu_result,
    output logic [DATA_W-1:0]   bus_value,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [DATA_W-1:0]   ac_q,
    output logic [DATA_W-1:0]   dr_q,
    output logic [DATA_W-1:0]   ir_q,
    output logic [IO_W-1:0]     out_char
);

    localparam int EXT_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] src_ext [NUM_SRC];
    logic [ADDR_W-1:0] ar_q;

    // One register per slot. The width is chosen by slot, and the accumulator takes the ALU result.
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam int W = (gi == IDX_AR || gi == IDX_PC) ? ADDR_W : DATA_W;
        logic [W-1:0] d_w;
        logic [W-1:0] q_w;

        if (gi == IDX_AC) begin : g_alu_in
            assign d_w = alu_result[W-1:0];
        end else begin : g_bus_in
            assign d_w = bus_value[W-1:0];
        end

        bus_reg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_strb[gi]),
            .ld    (ld_strb[gi]),
            .inc   (inc_strb[gi]),
            .d     (d_w),
            .q     (q_w)
        );

        assign src_ext[gi] = DATA_W'(q_w);
    end

    assign src_ext[IDX_MEM] = mem_rdata;

    bus_source_mux #(.DATA_W(DATA_W)) u_mux (
        .sel (bus_sel),
        .src (src_ext),
        .bus (bus_value)
    );

    // Output character register: captures the low byte of the bus.
    bus_reg #(.W(IO_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .ld    (out_ld),
        .inc   (1'b0),
        .d     (bus_value[IO_W-1:0]),
        .q     (out_char)
    );

    assign ar_q      = src_ext[IDX_AR][ADDR_W-1:0];
    assign mem_addr  = ar_q;
    assign mem_wdata = bus_value;
    assign ac_q      = src_ext[IDX_AC];
    assign dr_q      = src_ext[IDX_DR];
    assign ir_q      = src_ext[IDX_IR];

    p_addr_on_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SEL_W'(SEL_AR)) |-> (bus_value[ADDR_W-1:0] == mem_addr));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SEL_W'(SEL_AR) || bus_sel == SEL_W'(SEL_PC))
            |-> (bus_value[DATA_W-1:ADDR_W] == EXT_W'(0)));

    p_mem_on_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == SEL_W'(SEL_MEM)) |-> (bus_value == mem_rdata));

    p_ar_loads_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_strb[IDX_AR] && !clr_strb[IDX_AR]) |=> (mem_addr == $past(bus_value[ADDR_W-1:0])));

    p_out_low_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_ld |=> (out_char == $past(bus_value[IO_W-1:0])));

endmodule

// File: tb/shared_bus_datapath_tb_top.sv
module shared_bus_datapath_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [2:0]  sel;
        logic [5:0]  ld;
        logic [5:0]  inc;
        logic [5:0]  clr;
        logic [15:0] mem;
        logic [15:0] alu;
        logic [2:0]  rsel;
        logic [15:0] expv;
        logic [7:0]  req;
    } vec_t;

    // Strobe bits: 0 AR, 1 PC, 2 DR, 3 AC, 4 IR, 5 TR. The state carries over from row to row.
    localparam vec_t VECS [NV] = '{
        '{3'd7, 6'h10, 6'h00, 6'h00, 16'h1234, 16'h0000, 3'd5, 16'h1234, 8'd6},  // R6 IR from mem
        '{3'd7, 6'h01, 6'h00, 6'h00, 16'hABCD, 16'h0000, 3'd1, 16'h0BCD, 8'd4},  // R4 AR truncation
        '{3'd1, 6'h02, 6'h00, 6'h00, 16'h0000, 16'h0000, 3'd2, 16'h0BCD, 8'd3},  // R3 PC from AR
        '{3'd0, 6'h00, 6'h02, 6'h00, 16'h0000, 16'h0000, 3'd2, 16'h0BCE, 8'd8},  // R8 PC inc
        '{3'd7, 6'h04, 6'h00, 6'h00, 16'h5A5A, 16'h0000, 3'd3, 16'h5A5A, 8'd6},  // R6 DR from mem
        '{3'd4, 6'h0C, 6'h00, 6'h00, 16'h0000, 16'h5A5A, 3'd4, 16'h5A5A, 8'd7},  // R7 exchange AC side
        '{3'd0, 6'h00, 6'h00, 6'h00, 16'h0000, 16'h0000, 3'd3, 16'h0000, 8'd7},  // R7 exchange DR side
        '{3'd5, 6'h20, 6'h00, 6'h00, 16'h0000, 16'h0000, 3'd6, 16'h1234, 8'd2},  // R2 TR from IR
        '{3'd7, 6'h20, 6'h20, 6'h20, 16'hFFFF, 16'h0000, 3'd6, 16'h0000, 8'd9},  // R9 clear wins
        '{3'd7, 6'h04, 6'h04, 6'h00, 16'h0010, 16'h0000, 3'd3, 16'h0010, 8'd9},  // R9 load over inc
        '{3'd0, 6'h00, 6'h08, 6'h00, 16'h0000, 16'h0000, 3'd4, 16'h5A5B, 8'd8},  // R8 AC inc
        '{3'd0, 6'h00, 6'h00, 6'h00, 16'h0000, 16'h0000, 3'd0, 16'h0000, 8'd2}   // R2 code 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [5:0]  ld_strb = '0, inc_strb = '0, clr_strb = '0;
    logic        out_ld = 1'b0;
    logic [15:0] mem_rdata = '0, alu_result = '0;
    logic [15:0] bus_value, mem_wdata, ac_q, dr_q, ir_q;
    logic [11:0] mem_addr;
    logic [7:0]  out_char;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    shared_bus_datapath dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .ld_strb    (ld_strb),
        .inc_strb   (inc_strb),
        .clr_strb   (clr_strb),
        .out_ld     (out_ld),
        .mem_rdata  (mem_rdata),
        .alu_result (alu_result),
        .bus_value  (bus_value),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .ac_q       (ac_q),
        .dr_q       (dr_q),
        .ir_q       (ir_q),
        .out_char   (out_char)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    // Set the strobes after a falling edge, let one rising edge pass, then drop the strobes.
    task automatic step(input logic [2:0] sel, input logic [5:0] ld, input logic [5:0] inc,
                        input logic [5:0] clr, input logic ol,
                        input logic [15:0] mem, input logic [15:0] alu);
        @(negedge clk);
        bus_sel = sel; ld_strb = ld; inc_strb = inc; clr_strb = clr; out_ld = ol;
        mem_rdata = mem; alu_result = alu;
        @(posedge clk);
        #1;
        ld_strb = '0; inc_strb = '0; clr_strb = '0; out_ld = 1'b0;
    endtask

    // Put a register on the bus and sample it combinationally before the next edge.
    task automatic readback(input logic [2:0] rsel, input string req, input logic [15:0] expv);
        bus_sel = rsel;
        #1;
        check(req, bus_value, expv);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int s = 1; s <= 6; s++) readback(3'(s), "R1", 16'h0000);
        check("R1", {8'h00, out_char}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].sel, VECS[i].ld, VECS[i].inc, VECS[i].clr, 1'b0,
                 VECS[i].mem, VECS[i].alu);
            readback(VECS[i].rsel, $sformatf("R%0d", VECS[i].req), VECS[i].expv);
        end

        // R5: the memory address follows the address register (0xBCD from row 2)
        check("R5", {4'h0, mem_addr}, 16'h0BCD);
        // R7: the exchanged values are visible on the accumulator and data register outputs
        check("R7", ac_q, 16'h5A5B);
        check("R6", dr_q, 16'h0010);
        check("R6", ir_q, 16'h1234);

        // R4 and R5: AR loads 0xF123 and keeps 0x123
        step(3'd7, 6'h01, 6'h00, 6'h00, 1'b0, 16'hF123, 16'h0);
        check("R5", {4'h0, mem_addr}, 16'h0123);
        readback(3'd1, "R3", 16'h0123);

        // R8: PC wraps at 12 bits
        step(3'd7, 6'h02, 6'h00, 6'h00, 1'b0, 16'hFFFF, 16'h0);
        readback(3'd2, "R4", 16'h0FFF);
        step(3'd0, 6'h00, 6'h02, 6'h00, 1'b0, 16'h0, 16'h0);
        readback(3'd2, "R8", 16'h0000);

        // R8: AC wraps at 16 bits
        step(3'd0, 6'h08, 6'h00, 6'h00, 1'b0, 16'h0, 16'hFFFF);
        step(3'd0, 6'h00, 6'h08, 6'h00, 1'b0, 16'h0, 16'h0);
        check("R8", ac_q, 16'h0000);

        // R7: an AC load ignores the bus and takes the ALU result
        step(3'd7, 6'h08, 6'h00, 6'h00, 1'b0, 16'h1111, 16'h2222);
        check("R7", ac_q, 16'h2222);

        // R11: the output register takes the low byte of the bus
        step(3'd7, 6'h00, 6'h00, 6'h00, 1'b1, 16'h12C3, 16'h0);
        check("R11", {8'h00, out_char}, 16'h00C3);

        // R10: write data tracks the bus
        bus_sel = 3'd4; #1;
        check("R10", mem_wdata, 16'h2222);
        mem_rdata = 16'h7E81; bus_sel = 3'd7; #1;
        check("R10", mem_wdata, 16'h7E81);
        check("R2", bus_value, 16'h7E81);

        // R12: no strobes leave AC and out_char unchanged
        step(3'd7, 6'h00, 6'h00, 6'h00, 1'b0, 16'h9999, 16'h9999);
        check("R12", ac_q, 16'h2222);
        check("R12", {8'h00, out_char}, 16'h00C3);

        // R1: a synchronous reset clears the state again
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        readback(3'd4, "R1", 16'h0000);
        check("R1", {4'h0, mem_addr}, 16'h0000);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule